// File: doc/BRIEF.md
# External and Pin-Change Interrupt Controller

This block collects interrupt requests from pins for a small microcontroller core. Eight dedicated external inputs each have their own enable bit, a 2-bit trigger-select field and a sticky flag. A trigger can be a low level, any change, a falling edge or a rising edge. Thirteen further pins are split into two pin-change groups of eight and five. Each pin in a group has a mask bit, and each group has one enable bit and one shared flag. Any change on a masked pin of a group sets that group's flag.

Every pin passes through a two-stage synchroniser. Edges are found by comparing the synchronised value with its value one clock earlier. Triggers are taken from the pin value whatever drives the pin, so software can raise an interrupt by driving the pin itself. Requests go to the core only while the global interrupt-enable input is high. The core clears a flag with a one-cycle acknowledge pulse for that vector. Software clears a flag by writing a one to it. All registers are read and written over a byte-wide bus with a 3-bit address. Writes take effect on the clock edge, and reads are combinational.

Top module: `extint_ctrl`

## Requirements
- R1: After reset, every register reads 0x00, and `ext_irq` and `pc_irq` are 0.
- R2: `ext_irq[n]` is 1 only while bit n of the external enable register (address 0) is 1 and `gie` is 1.
- R3: Input n has a trigger-select field at bits [2(n mod 4)+1 : 2(n mod 4)] of address 2 (inputs 0 to 3) or address 3 (inputs 4 to 7). The codes are 00 low level, 01 any change, 10 falling edge and 11 rising edge. For the three edge codes, flag bit n in the external flag register (address 1) reads 1 from the third clock edge after the pin changes, counting the two synchroniser stages and the flag register.
- R4: Writing a 1 to a bit of address 1 clears that flag. Writing a 0 leaves the flag unchanged.
- R5: A one-cycle pulse on `ext_ack[n]` clears flag n.
- R6: While input n uses code 00, flag n reads 0 and `ext_irq[n]` follows the inverted synchronised pin, gated as in R2.
- R7: If a trigger and a clear (write-one or acknowledge) hit the same flag in the same cycle, the flag stays 1.
- R8: The pin-change enable register (address 4) keeps bits 1:0, one for each group. Its bits 7:2 read 0 and ignore writes. In the pin-change flag register (address 5), bits 7:2 read 0. In the group-1 mask register (address 7), bits 7:5 read 0.
- R9: A change on pin k of `pc_pin` sets the flag of its group (bit 0 of address 5 for pins 0 to 7, bit 1 for pins 8 to 12), but only if the pin's mask bit is 1. The mask bit is at bit k of address 6 for group 0 and bit k-8 of address 7 for group 1. A change on an unmasked pin has no effect.
- R10: `pc_irq[g]` equals the group flag AND the group enable AND `gie`. A group flag is cleared by writing a 1 to its bit of address 5 or by a pulse on `pc_ack[g]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| ext_pin | input | 8 | External interrupt pins |
| pc_pin | input | 13 | Pin-change pins (group 0: 7:0, group 1: 12:8) |
| gie | input | 1 | Global interrupt enable from the core |
| ext_ack | input | 8 | Vector acknowledge pulses, external inputs |
| pc_ack | input | 2 | Vector acknowledge pulses, pin-change groups |
| ext_irq | output | 8 | External interrupt requests |
| pc_irq | output | 2 | Pin-change group requests |

## Verification
The bench aims at a write-one clear that lands in the exact cycle a new edge is detected. A design that lets the clear win would silently lose that interrupt. Level mode is checked for a flag that stays at zero while the request tracks the pin. A design that latched the level would keep requesting after the pin went high. Unmasked pin-change pins are toggled to show they leave the group flag alone, and the reserved bits of the control registers are written with ones. Randomised trigger-select codes and pin patterns compare every flag against an edge model, which catches swapped encodings or edges taken from the wrong synchroniser stage.

// File: rtl/extint_pkg.sv
package extint_pkg;

    localparam int EXT_N   = 8;
    localparam int GROUPS  = 2;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    typedef enum logic [2:0] {
        A_EXT_MASK = 3'd0,
        A_EXT_FLAG = 3'd1,
        A_SENSE_LO = 3'd2,
        A_SENSE_HI = 3'd3,
        A_PC_CTRL  = 3'd4,
        A_PC_FLAG  = 3'd5,
        A_PC_MASK0 = 3'd6,
        A_PC_MASK1 = 3'd7
    } reg_addr_e;

    // Edge-class trigger for one synchronised pin.
    function automatic logic edge_hit(sense_e s, logic cur, logic prev);
        unique case (s)
            SENSE_ANY:  edge_hit = cur ^ prev;
            SENSE_FALL: edge_hit = prev & ~cur;
            SENSE_RISE: edge_hit = cur & ~prev;
            default:    edge_hit = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    logic [W-1:0] meta_q, sync_q, hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            hist_q <= '0;
        end else begin
            meta_q <= pin;
            sync_q <= meta_q;
            hist_q <= sync_q;
        end
    end

    assign cur  = sync_q;
    assign prev = hist_q;
endmodule

// File: rtl/ext_channel.sv
module ext_channel
    import extint_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cur,
    input  logic   prev,
    input  sense_e sense,
    input  logic   enable,
    input  logic   gie,
    input  logic   ack,
    input  logic   wclr,
    output logic   flag,
    output logic   irq
);
    logic flag_q;
    logic hit;
    logic level_mode;

    assign level_mode = (sense == SENSE_LOW);
    assign hit        = edge_hit(sense, cur, prev);

    always_ff @(posedge clk) begin
        if (rst || level_mode)
            flag_q <= 1'b0;
        else if (hit)
            flag_q <= 1'b1;
        else if (ack || wclr)
            flag_q <= 1'b0;
    end

    assign flag = flag_q;
    assign irq  = enable & gie & (level_mode ? ~cur : flag_q);

    p_level_flag_zero_r6: assert property (@(posedge clk) disable iff (rst)
        level_mode |=> !flag_q);
    p_trigger_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (hit && !level_mode) |=> flag_q);
    p_ack_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (ack && !hit) |=> !flag_q);
endmodule

// File: rtl/pcint_group.sv
module pcint_group #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] cur,
    input  logic [N-1:0] prev,
    input  logic [N-1:0] mask,
    input  logic         enable,
    input  logic         gie,
    input  logic         ack,
    input  logic         wclr,
    output logic         flag,
    output logic         irq
);
    logic flag_q;
    logic hit;

    assign hit = |((cur ^ prev) & mask);

    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else if (hit)
            flag_q <= 1'b1;
        else if (ack || wclr)
            flag_q <= 1'b0;
    end

    assign flag = flag_q;
    assign irq  = flag_q & enable & gie;

    p_group_set_r9: assert property (@(posedge clk) disable iff (rst)
        hit |=> flag_q);
    p_group_clear_r10: assert property (@(posedge clk) disable iff (rst)
        ((ack || wclr) && !hit) |=> !flag_q);
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
    import extint_pkg::*;
#(
    parameter int PC0_N = 8,
    parameter int PC1_N = 5
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [2:0]             reg_addr,
    input  logic                   reg_wr,
    input  logic [7:0]             reg_wdata,
    output logic [7:0]             reg_rdata,
    input  logic [EXT_N-1:0]       ext_pin,
    input  logic [PC0_N+PC1_N-1:0] pc_pin,
    input  logic                   gie,
    input  logic [EXT_N-1:0]       ext_ack,
    input  logic [GROUPS-1:0]      pc_ack,
    output logic [EXT_N-1:0]       ext_irq,
    output logic [GROUPS-1:0]      pc_irq
);
    localparam int PC_W     = PC0_N + PC1_N;
    localparam int SENSE_W  = 2 * EXT_N;

    reg_addr_e            addr;
    logic [EXT_N-1:0]     mask_q;
    logic [SENSE_W-1:0]   sense_q;
    logic [GROUPS-1:0]    pc_en_q;
    logic [PC0_N-1:0]     pc_mask0_q;
    logic [PC1_N-1:0]     pc_mask1_q;

    logic [EXT_N-1:0]     ext_cur, ext_prev, ext_flag;
    logic [PC_W-1:0]      pc_cur, pc_prev;
    logic [GROUPS-1:0]    pc_flag;
    logic                 wr_ext_flag, wr_pc_flag;

    assign addr        = reg_addr_e'(reg_addr);
    assign wr_ext_flag = reg_wr && (addr == A_EXT_FLAG);
    assign wr_pc_flag  = reg_wr && (addr == A_PC_FLAG);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q     <= '0;
            sense_q    <= '0;
            pc_en_q    <= '0;
            pc_mask0_q <= '0;
            pc_mask1_q <= '0;
        end else if (reg_wr) begin
            unique case (addr)
                A_EXT_MASK: mask_q        <= reg_wdata[EXT_N-1:0];
                A_SENSE_LO: sense_q[7:0]  <= reg_wdata;
                A_SENSE_HI: sense_q[15:8] <= reg_wdata;
                A_PC_CTRL:  pc_en_q       <= reg_wdata[GROUPS-1:0];
                A_PC_MASK0: pc_mask0_q    <= reg_wdata[PC0_N-1:0];
                A_PC_MASK1: pc_mask1_q    <= reg_wdata[PC1_N-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (addr)
            A_EXT_MASK: reg_rdata[EXT_N-1:0]  = mask_q;
            A_EXT_FLAG: reg_rdata[EXT_N-1:0]  = ext_flag;
            A_SENSE_LO: reg_rdata             = sense_q[7:0];
            A_SENSE_HI: reg_rdata             = sense_q[15:8];
            A_PC_CTRL:  reg_rdata[GROUPS-1:0] = pc_en_q;
            A_PC_FLAG:  reg_rdata[GROUPS-1:0] = pc_flag;
            A_PC_MASK0: reg_rdata[PC0_N-1:0]  = pc_mask0_q;
            A_PC_MASK1: reg_rdata[PC1_N-1:0]  = pc_mask1_q;
            default: ;
        endcase
    end

    pin_sync #(.W(EXT_N)) u_ext_sync (
        .clk(clk), .rst(rst), .pin(ext_pin), .cur(ext_cur), .prev(ext_prev)
    );

    pin_sync #(.W(PC_W)) u_pc_sync (
        .clk(clk), .rst(rst), .pin(pc_pin), .cur(pc_cur), .prev(pc_prev)
    );

    for (genvar i = 0; i < EXT_N; i++) begin : g_ext
        ext_channel u_ch (
            .clk   (clk),
            .rst   (rst),
            .cur   (ext_cur[i]),
            .prev  (ext_prev[i]),
            .sense (sense_e'(sense_q[2*i +: 2])),
            .enable(mask_q[i]),
            .gie   (gie),
            .ack   (ext_ack[i]),
            .wclr  (wr_ext_flag && reg_wdata[i]),
            .flag  (ext_flag[i]),
            .irq   (ext_irq[i])
        );
    end

    pcint_group #(.N(PC0_N)) u_grp0 (
        .clk(clk), .rst(rst),
        .cur(pc_cur[PC0_N-1:0]), .prev(pc_prev[PC0_N-1:0]),
        .mask(pc_mask0_q), .enable(pc_en_q[0]), .gie(gie),
        .ack(pc_ack[0]), .wclr(wr_pc_flag && reg_wdata[0]),
        .flag(pc_flag[0]), .irq(pc_irq[0])
    );

    pcint_group #(.N(PC1_N)) u_grp1 (
        .clk(clk), .rst(rst),
        .cur(pc_cur[PC_W-1:PC0_N]), .prev(pc_prev[PC_W-1:PC0_N]),
        .mask(pc_mask1_q), .enable(pc_en_q[1]), .gie(gie),
        .ack(pc_ack[1]), .wclr(wr_pc_flag && reg_wdata[1]),
        .flag(pc_flag[1]), .irq(pc_irq[1])
    );

    p_ext_irq_gated_r2: assert property (@(posedge clk) disable iff (rst)
        ((ext_irq & ~mask_q) == '0) && ((ext_irq == '0) || gie));
    p_pc_irq_gated_r10: assert property (@(posedge clk) disable iff (rst)
        ((pc_irq & ~pc_en_q) == '0) && ((pc_irq == '0) || gie));
    p_pc_ctrl_reserved_r8: assert property (@(posedge clk) disable iff (rst)
        (addr == A_PC_CTRL || addr == A_PC_FLAG) |-> (reg_rdata[7:2] == 6'd0));
endmodule

// File: tb/extint_ctrl_test.sv
module extint_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [7:0]  ext_pin = '0;
    logic [12:0] pc_pin = '0;
    logic        gie = 1'b0;
    logic [7:0]  ext_ack = '0;
    logic [1:0]  pc_ack = '0;
    logic [7:0]  ext_irq;
    logic [1:0]  pc_irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    extint_ctrl uut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_pin(ext_pin),
        .pc_pin(pc_pin), .gie(gie), .ext_ack(ext_ack), .pc_ack(pc_ack),
        .ext_irq(ext_irq), .pc_irq(pc_irq)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk);
        #1 reg_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [1:0] sense_of(logic [15:0] s, int n);
        return s[2*n +: 2];
    endfunction

    // Expected flag after a single stable change old -> new (R3, R6)
    function automatic logic [7:0] exp_flags(logic [15:0] s, logic [7:0] o, logic [7:0] n);
        logic [7:0] f = '0;
        for (int i = 0; i < 8; i++) begin
            case (sense_of(s, i))
                2'b01: f[i] = o[i] ^ n[i];
                2'b10: f[i] = o[i] & ~n[i];
                2'b11: f[i] = ~o[i] & n[i];
                default: f[i] = 1'b0;
            endcase
        end
        return f;
    endfunction

    function automatic logic [7:0] exp_irq(logic [15:0] s, logic [7:0] f, logic [7:0] pins,
                                           logic [7:0] m, logic g);
        logic [7:0] q = '0;
        for (int i = 0; i < 8; i++)
            q[i] = m[i] & g & ((sense_of(s, i) == 2'b00) ? ~pins[i] : f[i]);
        return q;
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [15:0] s;
        logic [7:0] old_e, new_e, m, f;
        logic [12:0] old_p, new_p;
        logic [7:0] pm0;
        logic [4:0] pm1;
        logic [1:0] pen, pf;
        logic g;
        int seed;
        seed = 17;
        void'($urandom(seed));

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            check("R1 reg", {8'h0, d}, 16'h0);
        end
        check("R1 irq", {6'h0, pc_irq, ext_irq}, 16'h0);

        // R8: reserved bits
        wr(3'd4, 8'hFF); rd(3'd4, d); check("R8 pc_ctrl", {8'h0, d}, 16'h03);
        wr(3'd7, 8'hFF); rd(3'd7, d); check("R8 pc_mask1", {8'h0, d}, 16'h1F);
        wr(3'd4, 8'h00); wr(3'd7, 8'h00);

        // R3: rising on 0..3, falling on 4..7
        wr(3'd2, 8'hFF); wr(3'd3, 8'hAA);
        @(negedge clk) ext_pin = 8'hFF; settle();
        rd(3'd1, d); check("R3 rise", {8'h0, d}, 16'h0F);
        @(negedge clk) ext_pin = 8'h00; settle();
        rd(3'd1, d); check("R3 fall", {8'h0, d}, 16'hFF);
        // R4: zero write ignored, one write clears
        wr(3'd1, 8'h00); rd(3'd1, d); check("R4 write0", {8'h0, d}, 16'hFF);
        wr(3'd1, 8'hF0); rd(3'd1, d); check("R4 write1", {8'h0, d}, 16'h0F);

        // R2: gating
        wr(3'd0, 8'h01);
        @(negedge clk) gie = 1'b0; #1 check("R2 gie off", {8'h0, ext_irq}, 16'h0);
        @(negedge clk) gie = 1'b1; #1 check("R2 gie on", {8'h0, ext_irq}, 16'h01);

        // R5: acknowledge clears
        @(negedge clk) ext_ack = 8'h01;
        @(negedge clk) ext_ack = 8'h00;
        rd(3'd1, d); check("R5 ack", {8'h0, d}, 16'h0E);
        check("R5 irq", {8'h0, ext_irq}, 16'h0);
        wr(3'd1, 8'hFF);

        // R6: level mode on input 2
        wr(3'd2, 8'hCF); wr(3'd0, 8'h04);
        settle();
        rd(3'd1, d); check("R6 flag", {8'h0, d}, 16'h0);
        check("R6 irq low", {8'h0, ext_irq}, 16'h04);
        @(negedge clk) ext_pin = 8'h04; settle();
        check("R6 irq high", {8'h0, ext_irq}, 16'h0);
        rd(3'd1, d); check("R6 flag high", {8'h0, d}, 16'h0);

        // R7: trigger beats same-cycle clear on input 1 (any change)
        wr(3'd2, 8'h04);
        @(negedge clk) ext_pin[1] = 1'b1; settle();
        rd(3'd1, d); check("R7 pre", {8'h0, d}, 16'h02);
        @(negedge clk) ext_pin[1] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        reg_addr = 3'd1; reg_wdata = 8'h02; reg_wr = 1'b1;
        @(posedge clk);
        #1 reg_wr = 1'b0;
        rd(3'd1, d); check("R7 collide", {8'h0, d}, 16'h02);
        wr(3'd1, 8'hFF); wr(3'd0, 8'h00);

        // R9: group 0 mask filter
        wr(3'd6, 8'h04); wr(3'd4, 8'h01); wr(3'd7, 8'h10);
        @(negedge clk) pc_pin[0] = 1'b1; settle();
        rd(3'd5, d); check("R9 unmasked", {8'h0, d}, 16'h0);
        check("R9 irq unmasked", {14'h0, pc_irq}, 16'h0);
        @(negedge clk) pc_pin[2] = 1'b1; settle();
        rd(3'd5, d); check("R9 masked", {8'h0, d}, 16'h01);
        check("R10 irq", {14'h0, pc_irq}, 16'h01);
        @(negedge clk) pc_pin[12] = 1'b1; settle();
        rd(3'd5, d); check("R9 group1", {8'h0, d}, 16'h03);
        check("R10 group1 disabled", {14'h0, pc_irq}, 16'h01);
        @(negedge clk) pc_ack = 2'b10;
        @(negedge clk) pc_ack = 2'b00;
        rd(3'd5, d); check("R10 ack", {8'h0, d}, 16'h01);
        wr(3'd5, 8'h01); rd(3'd5, d); check("R10 write1", {8'h0, d}, 16'h0);

        // Random: R3, R6, R2, R9, R10
        old_e = ext_pin; old_p = pc_pin;
        for (int it = 0; it < 60; it++) begin
            s   = 16'($urandom);
            m   = 8'($urandom);
            g   = 1'($urandom);
            pm0 = 8'($urandom);
            pm1 = 5'($urandom);
            pen = 2'($urandom);
            wr(3'd2, s[7:0]); wr(3'd3, s[15:8]);
            wr(3'd0, m); wr(3'd6, pm0); wr(3'd7, {3'b0, pm1}); wr(3'd4, {6'b0, pen});
            @(negedge clk) gie = g;
            wr(3'd1, 8'hFF); wr(3'd5, 8'h03);
            new_e = 8'($urandom);
            new_p = 13'($urandom);
            @(negedge clk) begin ext_pin = new_e; pc_pin = new_p; end
            settle();
            f = exp_flags(s, old_e, new_e);
            rd(3'd1, d); check("R3 random flags", {8'h0, d}, {8'h0, f});
            check("R2 random irq", {8'h0, ext_irq}, {8'h0, exp_irq(s, f, new_e, m, g)});
            pf[0] = |((old_p[7:0] ^ new_p[7:0]) & pm0);
            pf[1] = |((old_p[12:8] ^ new_p[12:8]) & pm1);
            rd(3'd5, d); check("R9 random group", {8'h0, d}, {14'h0, pf});
            check("R10 random irq", {14'h0, pc_irq}, {14'h0, pf & pen & {2{g}}});
            old_e = new_e; old_p = new_p;
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule